// File: doc/BRIEF.md
# DRAM Row Boundary Generator

This block turns an installed memory size, given in megabytes, into eight cumulative row boundary values. The values are counted in 8 MB units and are used by a memory decoder to tell which row a physical address falls in. A start pulse begins the generation. The size is rounded up to a whole number of 8 MB units and capped. It is then split greedily into modules of 128 MB, 32 MB and 8 MB. Each module takes the next row, one row per clock. Rows left over after the modules run out keep the last boundary.

The results first collect in a staging area. All eight row registers take the new values together on the last generation cycle, so a read made during generation still sees the old table. Once generation is idle, software can overwrite any row register through a byte write port. Each write is compared with the value the generator computed for that row, and the outcome is kept in a per-row mismatch mask. A non-zero mask means detection mode. One-cycle pulses mark entry into detection mode and the return to normal access.

Top module: `rowbound_gen`

## Requirements
- R1: A size that is not a multiple of 8 MB is rounded up to the next multiple. For example, 1 MB yields one 8 MB unit, so row 0 reads 1.
- R2: After rounding, the size is limited to 1024 MB (128 units). Any larger input gives the same table as 1024 MB: rows 16, 32, … 128.
- R3: Modules are taken largest first: as many 128 MB modules (16 units) as fit, then 32 MB (4 units), then 8 MB (1 unit). Row k holds the running sum of the module units placed in rows 0..k. For example, 200 MB gives rows 16, 20, 24, 25.
- R4: At most eight rows are filled. Memory left after row 7 is dropped. For example, 1016 MB gives rows 16..112 followed by 116.
- R5: Rows beyond the last placed module repeat the last boundary. If no module was placed (size 0), they read 0.
- R6: `start_i` is accepted only when `busy_o` is low. `busy_o` is then high for exactly 8 cycles. `done_o` rises on the edge where `busy_o` falls and stays high until the next accepted start. A start while busy is ignored.
- R7: `rd_data_o` shows row `rd_row_i` combinationally. During generation the rows keep their previous contents, and all eight change on the completion edge.
- R8: A write while idle stores `wr_data_i` in row `wr_row_i`. The write sets mask bit `wr_row_i` if the value differs from the computed value for that row, and clears the bit if the two are equal. Writes while busy have no effect.
- R9: Completion of a generation clears the whole mismatch mask.
- R10: `detect_o` is high while the mask is non-zero. `detect_enter_o` pulses for one cycle when the mask goes from zero to non-zero. `detect_exit_o` pulses for one cycle when the mask goes from non-zero to zero.
- R11: Reset clears all rows, the computed values, the mask, `busy_o`, `done_o` and both pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start generation (accepted when idle) |
| mem_mb_i | input | SIZE_W | Installed memory in MB |
| wr_en_i | input | 1 | Software row write strobe |
| wr_row_i | input | IDX_W | Row written |
| wr_data_i | input | DATA_W | Value written |
| rd_row_i | input | IDX_W | Row read |
| rd_data_o | output | DATA_W | Contents of row `rd_row_i` |
| busy_o | output | 1 | Generation in progress |
| done_o | output | 1 | Last generation has completed |
| mismatch_o | output | ROWS | Per-row mismatch mask |
| detect_o | output | 1 | Mask non-zero (detection mode) |
| detect_enter_o | output | 1 | One-cycle pulse when entering detection mode |
| detect_exit_o | output | 1 | One-cycle pulse when returning to normal mode |

## Verification
The bench targets several corner cases:
- Sizes that sit on a rounding edge (1, 1017 and 1025 MB). A missing round-up or a clamp applied before rounding gives boundaries one unit short or past 128.
- The 1016 MB case, which runs out of rows with memory left over. A generator that does not stop at row 8 would corrupt row 7 or wrap the index back to row 0.
- Zero and tiny sizes, which check that trailing rows repeat the last boundary rather than reading zero or a stale value.
- Software writes that match, miss and then re-match the computed values, and a completion that arrives while the mask is set. A design with a wrong compare source, or one that fails to clear the mask on completion, shows wrong mask bits or missing or doubled enter/exit pulses.
- Writes and a second start issued during generation. A design that accepts either shows rows that change early or a table built from the wrong size.

// File: rtl/drb_pkg.sv
package drb_pkg;
  localparam int N_MOD = 3;

  // module sizes in 8 MB units, index 0 largest
  function automatic int mod_units(int i);
    case (i)
      0:       return 16;
      1:       return 4;
      default: return 1;
    endcase
  endfunction

  typedef enum logic {ST_IDLE, ST_RUN} gen_state_e;
endpackage

// File: rtl/drb_size_norm.sv
module drb_size_norm #(
  parameter int SIZE_W  = 12,
  parameter int UNIT_MB = 8,
  parameter int MAX_MB  = 1024,
  parameter int UNIT_W  = 8
) (
  input  logic [SIZE_W-1:0] mb_i,
  output logic [UNIT_W-1:0] units_o
);
  localparam int SH        = $clog2(UNIT_MB);
  localparam int MAX_UNITS = MAX_MB / UNIT_MB;

  logic [SIZE_W:0] sum;
  logic [SIZE_W:0] rounded;

  always_comb begin
    sum     = {1'b0, mb_i} + (SIZE_W+1)'(UNIT_MB - 1);
    rounded = sum >> SH;
    if (rounded > (SIZE_W+1)'(MAX_UNITS)) units_o = UNIT_W'(MAX_UNITS);
    else                                  units_o = rounded[UNIT_W-1:0];
  end
endmodule

// File: rtl/drb_step_gen.sv
module drb_step_gen
  import drb_pkg::*;
#(
  parameter int ROWS   = 8,
  parameter int DATA_W = 8,
  parameter int UNIT_W = 8,
  localparam int IDX_W = $clog2(ROWS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [UNIT_W-1:0]      units_i,
  output logic                   busy_o,
  output logic                   commit_o,
  output logic [ROWS*DATA_W-1:0] stage_o
);
  gen_state_e              state_q;
  logic [IDX_W-1:0]        idx_q;
  logic [UNIT_W-1:0]       rem_q;
  logic [DATA_W-1:0]       acc_q;
  logic [DATA_W-1:0]       acc_nx;
  logic [UNIT_W-1:0]       step;
  logic [DATA_W-1:0]       stage_q [ROWS];

  // largest module that still fits; smallest checked first so larger overrides
  always_comb begin
    step = '0;
    for (int i = N_MOD - 1; i >= 0; i--) begin
      if (rem_q >= UNIT_W'(mod_units(i))) step = UNIT_W'(mod_units(i));
    end
    acc_nx = acc_q + DATA_W'(step);
  end

  assign busy_o   = (state_q == ST_RUN);
  assign commit_o = busy_o && (idx_q == IDX_W'(ROWS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      rem_q   <= '0;
      acc_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          idx_q   <= '0;
          rem_q   <= units_i;
          acc_q   <= '0;
        end
        default: begin
          acc_q <= acc_nx;
          rem_q <= rem_q - step;
          idx_q <= idx_q + 1'b1;
          if (idx_q == IDX_W'(ROWS - 1)) state_q <= ST_IDLE;
        end
      endcase
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      stage_q[r] <= '0;
      else if (busy_o && idx_q == IDX_W'(r))            stage_q[r] <= acc_nx;
    end
    // last row bypasses so the commit edge sees the full table
    assign stage_o[r*DATA_W +: DATA_W] =
      (busy_o && idx_q == IDX_W'(r)) ? acc_nx : stage_q[r];
  end
endmodule

// File: rtl/drb_row_file.sv
module drb_row_file #(
  parameter int ROWS   = 8,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(ROWS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   commit_i,
  input  logic [ROWS*DATA_W-1:0] stage_i,
  input  logic                   wr_en_i,
  input  logic [IDX_W-1:0]       wr_row_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  input  logic [IDX_W-1:0]       rd_row_i,
  output logic [DATA_W-1:0]      rd_data_o,
  output logic [ROWS*DATA_W-1:0] rows_o,
  output logic [ROWS-1:0]        mask_o,
  output logic                   enter_o,
  output logic                   exit_o
);
  logic [DATA_W-1:0] row_q  [ROWS];
  logic [DATA_W-1:0] calc_q [ROWS];
  logic [ROWS-1:0]   mask_q, mask_d;
  logic              enter_q, exit_q;

  always_comb begin
    mask_d = mask_q;
    if (commit_i)     mask_d = '0;
    else if (wr_en_i) mask_d[wr_row_i] = (wr_data_i != calc_q[wr_row_i]);
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        row_q[r]  <= '0;
        calc_q[r] <= '0;
      end else if (commit_i) begin
        row_q[r]  <= stage_i[r*DATA_W +: DATA_W];
        calc_q[r] <= stage_i[r*DATA_W +: DATA_W];
      end else if (wr_en_i && wr_row_i == IDX_W'(r)) begin
        row_q[r]  <= wr_data_i;
      end
    end
    assign rows_o[r*DATA_W +: DATA_W] = row_q[r];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      enter_q <= 1'b0;
      exit_q  <= 1'b0;
    end else begin
      mask_q  <= mask_d;
      enter_q <= (mask_q == '0) && (mask_d != '0);
      exit_q  <= (mask_q != '0) && (mask_d == '0);
    end
  end

  assign rd_data_o = row_q[rd_row_i];
  assign mask_o    = mask_q;
  assign enter_o   = enter_q;
  assign exit_o    = exit_q;
endmodule

// File: rtl/rowbound_gen.sv
module rowbound_gen #(
  parameter int SIZE_W  = 12,
  parameter int ROWS    = 8,
  parameter int DATA_W  = 8,
  parameter int UNIT_MB = 8,
  parameter int MAX_MB  = 1024,
  localparam int IDX_W  = $clog2(ROWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SIZE_W-1:0] mem_mb_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_row_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_row_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [ROWS-1:0]   mismatch_o,
  output logic              detect_o,
  output logic              detect_enter_o,
  output logic              detect_exit_o
);
  localparam int UNIT_W = $clog2(MAX_MB / UNIT_MB + 1);

  logic [UNIT_W-1:0]       units;
  logic                    busy, commit, start_ok, wr_ok, done_q;
  logic [ROWS*DATA_W-1:0]  stage, rows_flat;

  assign start_ok = start_i && !busy;
  assign wr_ok    = wr_en_i && !busy;

  drb_size_norm #(.SIZE_W(SIZE_W), .UNIT_MB(UNIT_MB), .MAX_MB(MAX_MB), .UNIT_W(UNIT_W)) u_norm (
    .mb_i(mem_mb_i), .units_o(units)
  );

  drb_step_gen #(.ROWS(ROWS), .DATA_W(DATA_W), .UNIT_W(UNIT_W)) u_gen (
    .clk_i, .rst_ni, .start_i(start_ok), .units_i(units),
    .busy_o(busy), .commit_o(commit), .stage_o(stage)
  );

  drb_row_file #(.ROWS(ROWS), .DATA_W(DATA_W)) u_rows (
    .clk_i, .rst_ni, .commit_i(commit), .stage_i(stage),
    .wr_en_i(wr_ok), .wr_row_i, .wr_data_i, .rd_row_i, .rd_data_o,
    .rows_o(rows_flat), .mask_o(mismatch_o),
    .enter_o(detect_enter_o), .exit_o(detect_exit_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       done_q <= 1'b0;
    else if (commit)   done_q <= 1'b1;
    else if (start_ok) done_q <= 1'b0;
  end

  assign busy_o   = busy;
  assign done_o   = done_q;
  assign detect_o = |mismatch_o;
endmodule

// File: rtl/rowbound_gen_chk.sv
module rowbound_gen_chk #(
  parameter int ROWS   = 8,
  parameter int DATA_W = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   busy_o,
  input logic                   done_o,
  input logic [ROWS-1:0]        mismatch_o,
  input logic                   detect_enter_o,
  input logic                   detect_exit_o,
  input logic [ROWS*DATA_W-1:0] rows_flat
);
  AST_DONE_ON_FINISH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R6
  AST_NO_DONE_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o); // R6
  AST_ROWS_HELD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(rows_flat)); // R7
  AST_MASK_CLEAR_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (mismatch_o == '0)); // R9
  AST_ENTER_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detect_enter_o |-> (mismatch_o != '0 && $past(mismatch_o) == '0)); // R10
  AST_EXIT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detect_exit_o |-> (mismatch_o == '0 && $past(mismatch_o) != '0)); // R10
  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(detect_enter_o && detect_exit_o)); // R10
endmodule

bind rowbound_gen rowbound_gen_chk #(.ROWS(ROWS), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .mismatch_o(mismatch_o), .detect_enter_o(detect_enter_o),
  .detect_exit_o(detect_exit_o), .rows_flat(rows_flat)
);

// File: tb/tb_rowbound_gen.sv
`timescale 1ns/1ps
module tb_rowbound_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [11:0] mem_mb_i = '0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_row_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic [2:0]  rd_row_i;
  logic [7:0]  rd_data_o;
  logic        busy_o, done_o, detect_o, detect_enter_o, detect_exit_o;
  logic [7:0]  mismatch_o;

  int checks = 0, fails = 0, cyc = 0;
  logic       rot_en = 1'b1;
  logic [2:0] rot_cnt = '0, fix_row = '0;
  assign rd_row_i = rot_en ? rot_cnt : fix_row;

  always #10 clk_i = ~clk_i;

  rowbound_gen dut (.*);

  // reference model state
  int m_rows[8], m_calc[8], m_pend[8];
  int m_mask = 0, m_cnt = 0;
  bit m_busy = 0, m_done = 0, m_enter = 0, m_exit = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic void build(int mb);
    int u, row, drb, mc;
    int sz[3] = '{16, 4, 1};
    u = (mb + 7) / 8;
    if (u > 128) u = 128;
    row = 0; drb = 0;
    foreach (sz[t]) begin
      mc = u / sz[t];
      u  = u % sz[t];
      for (int j = 0; j < mc && row < 8; j++) begin
        drb += sz[t];
        m_pend[row++] = drb;
      end
    end
    while (row < 8) m_pend[row++] = drb;
  endfunction

  always @(negedge clk_i) rot_cnt <= rot_cnt + 3'd1;

  always @(posedge clk_i) begin
    int old, nm;
    cyc++;
    if (!rst_ni) begin
      foreach (m_rows[i]) begin m_rows[i] = 0; m_calc[i] = 0; end
      m_mask = 0; m_busy = 0; m_done = 0; m_enter = 0; m_exit = 0; m_cnt = 0;
    end else begin
      old = m_mask; nm = old;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == 8) begin
          foreach (m_rows[i]) begin m_rows[i] = m_pend[i]; m_calc[i] = m_pend[i]; end
          nm = 0; m_busy = 0; m_done = 1;
        end
      end else begin
        if (wr_en_i) begin
          m_rows[wr_row_i] = wr_data_i;
          if (int'(wr_data_i) != m_calc[wr_row_i]) nm = nm | (1 << wr_row_i);
          else nm = nm & ~(1 << wr_row_i);
        end
        if (start_i) begin build(int'(mem_mb_i)); m_busy = 1; m_cnt = 0; m_done = 0; end
      end
      m_enter = (old == 0) && (nm != 0);
      m_exit  = (old != 0) && (nm == 0);
      m_mask  = nm;
    end
    #5;
    chk("R7", "rd_data", int'(rd_data_o), m_rows[rd_row_i]);
    chk("R8", "mismatch", int'(mismatch_o), m_mask);
    chk("R6", "busy", int'(busy_o), int'(m_busy));
    chk("R6", "done", int'(done_o), int'(m_done));
    chk("R10", "detect", int'(detect_o), int'(m_mask != 0));
    chk("R10", "enter", int'(detect_enter_o), int'(m_enter));
    chk("R10", "exit", int'(detect_exit_o), int'(m_exit));
  end

  task automatic gen(int mb);
    @(negedge clk_i); mem_mb_i = 12'(mb); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    while (busy_o) @(negedge clk_i);
  endtask

  task automatic wr(int row, int d);
    @(negedge clk_i); wr_en_i = 1'b1; wr_row_i = 3'(row); wr_data_i = 8'(d);
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic expect_row(string req, int row, int exp);
    @(negedge clk_i); rot_en = 1'b0; fix_row = 3'(row);
    #2 chk(req, $sformatf("row%0d", row), int'(rd_data_o), exp);
    rot_en = 1'b1;
  endtask

  task automatic expect_table(string req, int e0, int e1, int e2, int e3,
                              int e4, int e5, int e6, int e7);
    int e[8] = '{e0, e1, e2, e3, e4, e5, e6, e7};
    foreach (e[i]) expect_row(req, i, e[i]);
  endtask

  initial begin
    int bcnt;
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk("R11", "busy_rst", int'(busy_o), 0);
    chk("R11", "mask_rst", int'(mismatch_o), 0);
    rst_ni = 1'b1;
    expect_table("R11", 0, 0, 0, 0, 0, 0, 0, 0);

    gen(1);    expect_table("R1", 1, 1, 1, 1, 1, 1, 1, 1);
    gen(0);    expect_table("R5", 0, 0, 0, 0, 0, 0, 0, 0);
    gen(24);   expect_table("R5", 1, 2, 3, 3, 3, 3, 3, 3);
    gen(200);  expect_table("R3", 16, 20, 24, 25, 25, 25, 25, 25);
    gen(1016); expect_table("R4", 16, 32, 48, 64, 80, 96, 112, 116);
    gen(4000); expect_table("R2", 16, 32, 48, 64, 80, 96, 112, 128);
    gen(1017); expect_table("R1", 16, 32, 48, 64, 80, 96, 112, 128);
    gen(1025); expect_table("R2", 16, 32, 48, 64, 80, 96, 112, 128);

    // R6 busy length and done persistence
    @(negedge clk_i); mem_mb_i = 12'd200; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    bcnt = 0;
    while (busy_o) begin bcnt++; @(negedge clk_i); end
    chk("R6", "busy_cycles", bcnt, 8);
    repeat (3) @(negedge clk_i);
    chk("R6", "done_held", int'(done_o), 1);

    // R8 writes and R10 detection
    wr(2, 24); chk("R8", "match_write", int'(mismatch_o), 8'h00);
    wr(1, 99); chk("R8", "miss_write", int'(mismatch_o), 8'h02);
    wr(5, 0);  chk("R8", "miss_write2", int'(mismatch_o), 8'h22);
    expect_row("R8", 1, 99);
    wr(1, 20); chk("R8", "rematch", int'(mismatch_o), 8'h20);
    wr(5, 25); chk("R10", "back_normal", int'(detect_o), 0);

    // R7/R8 writes and second start ignored while busy; R9 mask cleared
    wr(0, 7);
    chk("R10", "detect_on", int'(detect_o), 1);
    @(negedge clk_i); mem_mb_i = 12'd24; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0; mem_mb_i = 12'd1024;
    wr_en_i = 1'b1; wr_row_i = 3'd3; wr_data_i = 8'hAA;
    @(negedge clk_i); wr_en_i = 1'b0;
    start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    expect_row("R7", 3, 25);
    expect_row("R7", 0, 7);
    while (busy_o) @(negedge clk_i);
    chk("R9", "mask_after_done", int'(mismatch_o), 0);
    expect_table("R6", 1, 2, 3, 3, 3, 3, 3, 3);

    // R11 reset in the middle of generation
    @(negedge clk_i); mem_mb_i = 12'd512; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R11", "busy_midrst", int'(busy_o), 0);
    chk("R11", "done_midrst", int'(done_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    expect_table("R11", 0, 0, 0, 0, 0, 0, 0, 0);

    repeat (3) @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule